// File: doc/BRIEF.md
# Standby STOP Sequencer

This block puts a small microcontroller subsystem into its deepest standby state and brings it back out. Software first loads a power-save mode field with the STOP code, then strobes a standby trigger. The sequencer then halts the oscillator and drops the CPU and peripheral clock enables. Peripherals marked as running from an external clock keep their enables.

While stopped, the sequencer watches the masked external and internal request lines. On a qualifying request it restarts the oscillator and counts a software-programmed stabilization wait. It then restores the clocks and reports how the CPU must resume. The CPU either branches to the interrupt handler, which acknowledges the request, or continues at the instruction after the one that entered STOP.

Reset leaves STOP at any time. The oscillator, CPU and interrupt controller stay outside the block. They appear only as plain control inputs, so there is no streaming data path and no pin uses a valid/ready handshake.

Top module: `stop_standby_ctrl`

## Requirements
- R1: A `trig_wr` pulse in NORMAL enters STOP on the next edge only if the mode field already holds `STOP_ENC` (default 2'b01) before that edge. A trigger with any other mode value, or a trigger given outside NORMAL, changes nothing.
- R2: In STOP, `osc_en` and `cpu_clk_en` are 0, and `per_clk_en[i]` equals `per_ext_clk[i]`.
- R3: In NORMAL, `osc_en`, `cpu_clk_en` and every `per_clk_en` bit are 1.
- R4: In STOP, a wake occurs on any `ext_req[i]` whose `ext_mask[i]` is 0. A wake also occurs on any `per_req[i]` whose `per_mask[i]` is 0, provided that peripheral is wake-capable. Mask bit 1 means masked. With the default `WAKE_CAP` of 3'b011, peripheral 2 cannot wake the block.
- R5: The `state_o` codes are NORMAL=0, STOP=1 and STABILIZE=2. A wake moves STOP to STABILIZE and loads the wait register value L. STABILIZE lasts L+1 cycles. During it `osc_en` is 1, while `cpu_clk_en` and the peripheral enables behave as in STOP.
- R6: While `intm` is 1, no request releases STOP.
- R7: If `ie` is 0 at the wake edge, `resume_branch` is 0.
- R8: If `ie` is 1, `in_service` is 1 and `req_prio` <= `svc_prio` at the wake edge, `resume_branch` is 0. The request is left pending. A larger priority number means more urgent.
- R9: If `ie` is 1 and either `in_service` is 0 or `req_prio` > `svc_prio` at the wake edge, `resume_branch` is 1. This means the request is acknowledged and the CPU branches to the handler.
- R10: `resume_valid` is a one-cycle pulse in the first NORMAL cycle after STABILIZE. `resume_branch` is meaningful while `resume_valid` is high.
- R11: The active-low asynchronous `rst_n` returns the block to NORMAL from any state. It clears the mode field to 0 and sets the wait register to `STAB_DEF` (default 8).
- R12: `stab_wr` may load the wait register in any state. A wake loads the value the register held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset, also a wake source |
| mode_wr | input | 1 | Write strobe for the power-save mode field |
| mode_wdata | input | MODE_W | New mode field value |
| trig_wr | input | 1 | Standby trigger strobe |
| stab_wr | input | 1 | Write strobe for the stabilization wait register |
| stab_wdata | input | CNT_W | New wait length in cycles |
| intm | input | 1 | 1 blocks request-driven release |
| ie | input | 1 | Global interrupt enable |
| in_service | input | 1 | An interrupt routine is running |
| svc_prio | input | PRIO_W | Priority of the routine in service |
| req_prio | input | PRIO_W | Priority of the most urgent pending request |
| ext_req | input | N_EXT | External request lines |
| ext_mask | input | N_EXT | Masks for external requests (1 = masked) |
| per_req | input | N_PER | Internal peripheral request lines |
| per_mask | input | N_PER | Masks for peripheral requests (1 = masked) |
| per_ext_clk | input | N_PER | Peripheral runs from an external clock |
| osc_en | output | 1 | Oscillator run enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | N_PER | Peripheral clock enables |
| state_o | output | 2 | Sequencer state code |
| resume_valid | output | 1 | Resume pulse |
| resume_branch | output | 1 | 1 = branch to handler, 0 = next instruction |

## Verification
The assertions take `trig_wr` and `mode_wr` to be synchronous strobes. They also take the priority and service inputs to be valid in the same cycle that a request line rises. The bench drives every input on the falling clock edge. It keeps `req_prio`, `svc_prio`, `in_service` and `ie` steady around each wake. Reset is asserted only on a falling edge and held for at least a cycle, which keeps the reset well-formed for the disable conditions.

// File: rtl/stop_pkg.sv
package stop_pkg;
  typedef enum logic [1:0] {
    SB_NORMAL = 2'd0,
    SB_STOP   = 2'd1,
    SB_STAB   = 2'd2
  } sb_state_e;
endpackage

// File: rtl/stop_wake_eval.sv
module stop_wake_eval #(
  parameter int N_EXT = 4,
  parameter int N_PER = 3,
  parameter int PRIO_W = 3,
  parameter logic [N_PER-1:0] WAKE_CAP = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_stop,
  input  logic              intm,
  input  logic              ie,
  input  logic              in_service,
  input  logic [PRIO_W-1:0] svc_prio,
  input  logic [PRIO_W-1:0] req_prio,
  input  logic [N_EXT-1:0]  ext_req,
  input  logic [N_EXT-1:0]  ext_mask,
  input  logic [N_PER-1:0]  per_req,
  input  logic [N_PER-1:0]  per_mask,
  output logic              wake,
  output logic              branch_q
);
  logic ext_hit, per_hit, take_branch;

  assign ext_hit = |(ext_req & ~ext_mask);
  assign per_hit = |(per_req & ~per_mask & WAKE_CAP);
  assign wake = (ext_hit | per_hit) & ~intm;
  assign take_branch = ie & (~in_service | (req_prio > svc_prio));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) branch_q <= 1'b0;
    else if (in_stop && wake) branch_q <= take_branch;
  end

  // R7
  ie_off_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && wake && !ie) |=> !branch_q);
  // R8
  low_prio_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && wake && ie && in_service && req_prio <= svc_prio) |=> !branch_q);
  // R6
  intm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intm |-> !wake);
endmodule

// File: rtl/stop_stab_counter.sv
module stop_stab_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R5
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));
endmodule

// File: rtl/stop_standby_ctrl.sv
module stop_standby_ctrl
  import stop_pkg::*;
#(
  parameter int MODE_W = 2,
  parameter logic [MODE_W-1:0] STOP_ENC = 2'b01,
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] STAB_DEF = 16'd8,
  parameter int N_EXT = 4,
  parameter int N_PER = 3,
  parameter int PRIO_W = 3,
  parameter logic [N_PER-1:0] WAKE_CAP = 3'b011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              trig_wr,
  input  logic              stab_wr,
  input  logic [CNT_W-1:0]  stab_wdata,
  input  logic              intm,
  input  logic              ie,
  input  logic              in_service,
  input  logic [PRIO_W-1:0] svc_prio,
  input  logic [PRIO_W-1:0] req_prio,
  input  logic [N_EXT-1:0]  ext_req,
  input  logic [N_EXT-1:0]  ext_mask,
  input  logic [N_PER-1:0]  per_req,
  input  logic [N_PER-1:0]  per_mask,
  input  logic [N_PER-1:0]  per_ext_clk,
  output logic              osc_en,
  output logic              cpu_clk_en,
  output logic [N_PER-1:0]  per_clk_en,
  output logic [1:0]        state_o,
  output logic              resume_valid,
  output logic              resume_branch
);
  sb_state_e         state_q;
  logic [MODE_W-1:0] psm_q;
  logic [CNT_W-1:0]  stab_q;
  logic              wake, cnt_zero, resume_q, in_stop;

  assign in_stop = (state_q == SB_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psm_q  <= '0;
      stab_q <= STAB_DEF;
    end else begin
      if (mode_wr) psm_q <= mode_wdata;
      if (stab_wr) stab_q <= stab_wdata;
    end
  end

  stop_wake_eval #(
    .N_EXT(N_EXT), .N_PER(N_PER), .PRIO_W(PRIO_W), .WAKE_CAP(WAKE_CAP)
  ) u_wake (
    .clk(clk), .rst_n(rst_n), .in_stop(in_stop), .intm(intm), .ie(ie),
    .in_service(in_service), .svc_prio(svc_prio), .req_prio(req_prio),
    .ext_req(ext_req), .ext_mask(ext_mask), .per_req(per_req),
    .per_mask(per_mask), .wake(wake), .branch_q(resume_branch)
  );

  stop_stab_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(in_stop && wake), .load_val(stab_q),
    .run(state_q == SB_STAB), .zero(cnt_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SB_NORMAL;
      resume_q <= 1'b0;
    end else begin
      resume_q <= 1'b0;
      unique case (state_q)
        SB_NORMAL: if (trig_wr && psm_q == STOP_ENC) state_q <= SB_STOP;
        SB_STOP:   if (wake) state_q <= SB_STAB;
        SB_STAB:   if (cnt_zero) begin
                     state_q  <= SB_NORMAL;
                     resume_q <= 1'b1;
                   end
        default:   state_q <= SB_NORMAL;
      endcase
    end
  end

  assign osc_en       = (state_q != SB_STOP);
  assign cpu_clk_en   = (state_q == SB_NORMAL);
  assign state_o      = state_q;
  assign resume_valid = resume_q;

  for (genvar i = 0; i < N_PER; i++) begin : g_pclk
    assign per_clk_en[i] = (state_q == SB_NORMAL) | per_ext_clk[i];
  end

  // R1
  bad_mode_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SB_NORMAL && psm_q != STOP_ENC) |=> state_q == SB_NORMAL);
  // R2
  stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_stop |-> (!cpu_clk_en && !osc_en && per_clk_en == per_ext_clk));
  // R6
  intm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && intm) |=> state_q == SB_STOP);
  // R10
  resume_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_valid |=> !resume_valid);
  // R10
  resume_after_stab_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_valid) |-> (state_q == SB_NORMAL && $past(state_q) == SB_STAB));
endmodule

// File: tb/stop_standby_ctrl_bench.sv
`timescale 1ns/1ps
module stop_standby_ctrl_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, mode_wr, trig_wr, stab_wr, intm, ie, in_service;
  logic [1:0] mode_wdata;
  logic [15:0] stab_wdata;
  logic [2:0] svc_prio, req_prio, per_req, per_mask, per_ext_clk, per_clk_en;
  logic [3:0] ext_req, ext_mask;
  logic osc_en, cpu_clk_en, resume_valid, resume_branch;
  logic [1:0] state_o;

  stop_standby_ctrl u_stop_standby_ctrl (.*);

  int checks = 0, errors = 0;
  string cur_req = "R11";
  string m_btag = "R7";
  int m_state, m_psm, m_stab, m_cnt, m_branch, m_rv;

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_psm = 0; m_stab = 8; m_cnt = 0; m_branch = 0; m_rv = 0;
    end else begin
      int ns, nc;
      bit wk;
      ns = m_state; nc = m_cnt; m_rv = 0; wk = 0;
      for (int i = 0; i < 4; i++) if (ext_req[i] && !ext_mask[i]) wk = 1;
      for (int i = 0; i < 2; i++) if (per_req[i] && !per_mask[i]) wk = 1;
      if (intm) wk = 0;
      if (m_state == 0) begin
        if (trig_wr && m_psm == 1) ns = 1;
      end else if (m_state == 1) begin
        if (wk) begin
          ns = 2; nc = m_stab;
          if (!ie) begin m_branch = 0; m_btag = "R7"; end
          else if (in_service && req_prio <= svc_prio) begin m_branch = 0; m_btag = "R8"; end
          else begin m_branch = 1; m_btag = "R9"; end
        end
      end else begin
        if (m_cnt == 0) begin ns = 0; m_rv = 1; end
        else nc = m_cnt - 1;
      end
      if (mode_wr) m_psm = mode_wdata;
      if (stab_wr) m_stab = stab_wdata;
      m_state = ns; m_cnt = nc;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    begin
      int e_per;
      string gtag;
      e_per = (m_state == 0) ? 7 : int'(per_ext_clk);
      gtag = (m_state == 0) ? "R3" : "R2";
      chk(int'(state_o) == m_state, cur_req, int'(state_o), m_state);
      chk(int'(osc_en) == int'(m_state != 1), (m_state == 2) ? "R5" : gtag, int'(osc_en), int'(m_state != 1));
      chk(int'(cpu_clk_en) == int'(m_state == 0), gtag, int'(cpu_clk_en), int'(m_state == 0));
      chk(int'(per_clk_en) == e_per, gtag, int'(per_clk_en), e_per);
      chk(int'(resume_valid) == m_rv, "R10", int'(resume_valid), m_rv);
      if (m_rv == 1) chk(int'(resume_branch) == m_branch, m_btag, int'(resume_branch), m_branch);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] v);
    @(negedge clk); mode_wr = 1; mode_wdata = v;
    @(negedge clk); mode_wr = 0;
  endtask

  task automatic trig();
    @(negedge clk); trig_wr = 1;
    @(negedge clk); trig_wr = 0;
  endtask

  task automatic set_stab(input int v);
    @(negedge clk); stab_wr = 1; stab_wdata = 16'(v);
    @(negedge clk); stab_wr = 0;
  endtask

  task automatic ext_pulse(input logic [3:0] v);
    @(negedge clk); ext_req = v;
    @(negedge clk); ext_req = '0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; mode_wr = 0; trig_wr = 0; stab_wr = 0; intm = 0; ie = 0;
    in_service = 0; mode_wdata = 0; stab_wdata = 0; svc_prio = 0; req_prio = 0;
    per_req = 0; per_mask = 0; per_ext_clk = 0; ext_req = 0; ext_mask = 0;
    cyc(3); rst_n = 1; cyc(2);                 // R11 reset state

    cur_req = "R1";                             // wrong mode: trigger ignored
    set_mode(2'b10); trig(); cyc(3);

    cur_req = "R2"; per_ext_clk = 3'b101; set_stab(3);
    set_mode(2'b01); trig(); cyc(2);
    trig(); cyc(1);                             // R1 trigger in STOP ignored
    cur_req = "R4"; ext_mask = 4'b0010; ext_req = 4'b0010; per_req = 3'b100;
    cyc(4); ext_req = 0; per_req = 0;           // masked / non-capable: no wake
    cur_req = "R7"; ext_mask = 0; ie = 0; ext_pulse(4'b0010); cyc(8);

    cur_req = "R6"; trig(); cyc(1); intm = 1; per_req = 3'b001; cyc(5);
    cur_req = "R4"; intm = 0; cyc(1); per_req = 0; cyc(8);

    cur_req = "R8"; ie = 1; in_service = 1; svc_prio = 4; req_prio = 4;
    trig(); cyc(2); ext_pulse(4'b0001); cyc(8);
    req_prio = 2; trig(); cyc(2); ext_pulse(4'b1000); cyc(8);

    cur_req = "R9"; req_prio = 6; trig(); cyc(2); ext_pulse(4'b0100); cyc(8);
    in_service = 0; req_prio = 0; trig(); cyc(2); ext_pulse(4'b0001); cyc(8);

    cur_req = "R5"; set_stab(0); trig(); cyc(2); ext_pulse(4'b0001); cyc(4);

    cur_req = "R12"; trig(); cyc(2); set_stab(5); ext_pulse(4'b0001); cyc(10);
    @(negedge clk); stab_wr = 1; stab_wdata = 2; ext_req = 4'b0001;  // same-edge write
    @(negedge clk); stab_wr = 0; ext_req = 0; cyc(2);
    trig(); cyc(2);
    @(negedge clk); stab_wr = 1; stab_wdata = 7; ext_req = 4'b0001;
    @(negedge clk); stab_wr = 0; ext_req = 0; cyc(12);

    cur_req = "R11"; trig(); cyc(2); ext_pulse(4'b0001); cyc(2);
    @(negedge clk); rst_n = 0; cyc(2); rst_n = 1; cyc(2);  // reset in STABILIZE
    trig(); cyc(3);                             // mode field was cleared
    set_mode(2'b01); trig(); cyc(2);
    @(negedge clk); rst_n = 0; cyc(1); rst_n = 1; cyc(2);  // reset in STOP
    set_mode(2'b01); trig(); cyc(2); ext_pulse(4'b0001); cyc(14); // default wait 8

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule